// File: doc/BRIEF.md
# Byte-Wide Data-Move Instruction Sequencer

This block fetches and runs a narrow family of 8-bit data-move instructions from a byte-wide synchronous memory. It keeps its own 16-bit program counter and five data registers: the accumulator and the H, L, D and E registers. Each instruction is split into machine cycles. There is one opcode fetch, then zero to two operand-byte reads, then up to two data reads or writes. The number of clock states in each machine cycle is fixed, so every instruction takes a fixed total number of states.

Memory read data is expected during the same cycle in which the address is presented. The sequencer holds the address and the strobe for the whole machine cycle and takes in the byte on the last state of that cycle. A write is strobed for one clock, in the last state of its cycle. The block pulses `done` on the final state of each instruction. It also shows the byte length of the most recently decoded instruction. Any opcode it does not recognise stops the block until reset.

Top module: `xfer_sequencer`

## Requirements
- R1: While `rst` is high, the block has pc 0, all five data registers at 0, `memWr`, `done` and `halted` low, and `memAddr` at 0. The first machine cycle after reset is an opcode fetch from address 0.
- R2: An opcode fetch lasts 4 clock states, with `memRd` high and `memAddr` equal to pc throughout. The pc advances by one after each opcode or operand byte is fetched, and it does not move during a write cycle.
- R3: Opcode 3Ah followed by an address (low byte first) loads the accumulator from that address. It takes 13 states and reports a length of 3.
- R4: Opcode 32h followed by an address (low byte first, so 32 00 24 targets 2400h) writes the accumulator to that address in one write strobe. It takes 13 states.
- R5: Opcode 2Ah followed by an address loads L from the address and H from the address plus one. It takes 16 states.
- R6: Opcode 22h followed by an address writes L to the address and H to the address plus one, in that order. It takes 16 states.
- R7: Opcode 21h (HL pair) or 11h (DE pair) followed by two data bytes loads the low register (L or E) from the first byte and the high register (H or D) from the second. It takes 10 states and reports a length of 3.
- R8: Opcode 12h writes the accumulator to the address formed as {D,E}. It takes 7 states and reports a length of 1.
- R9: `done` is high for exactly one clock, on the last state of each instruction. At that point `instrLen` holds the instruction's byte count.
- R10: Any other opcode raises `halted` after its 4-state fetch. From then until reset there is no memory read or write, and no register changes.
- R11: `memRd` and `memWr` are never high together. A machine cycle keeps its kind for all of its states.
- R12: The address plus one used by the H/L transfers wraps from FFFFh to 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 16 | Memory address, held for the whole machine cycle |
| memRd | output | 1 | Read cycle in progress |
| memWr | output | 1 | Write strobe, one clock at the end of a write cycle |
| memRdData | input | 8 | Byte returned by memory for `memAddr` |
| memWrData | output | 8 | Byte to write |
| done | output | 1 | Last state of an instruction |
| instrLen | output | 2 | Byte length of the last decoded instruction |
| halted | output | 1 | Unknown opcode seen; sequencer stopped |
| pcOut | output | 16 | Program counter |
| accOut | output | 8 | Accumulator |
| hOut | output | 8 | H register |
| lOut | output | 8 | L register |
| dOut | output | 8 | D register |
| eOut | output | 8 | E register |

## Verification
One straight-line program runs every supported opcode. The operands are chosen so that low and high bytes differ, which exposes any swap of byte order or any mix-up between the L/E and H/D destinations. The store instructions are given address operands and data that differ from the load data, so each captured write shows whether the right register went to the right address. A final H/L load and store at FFFFh checks the address wrap. A trailing unknown opcode, followed by a second reset, checks the stop behaviour and that reset clears everything again. The state count of every instruction is measured between `done` pulses, and this catches a wrong number of machine cycles or a wrong cycle length.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = 2 * DATA_W;
  localparam int FETCH_STATES = 4;
  localparam int MEM_STATES   = 3;
  localparam int MAX_STATES   = (FETCH_STATES > MEM_STATES) ? FETCH_STATES : MEM_STATES;
  localparam int TCNT_W       = $clog2(MAX_STATES);
  localparam int LEN_W        = 2;

  localparam logic [7:0] OPC_LD_ACC    = 8'h3A;
  localparam logic [7:0] OPC_ST_ACC    = 8'h32;
  localparam logic [7:0] OPC_LD_HL     = 8'h2A;
  localparam logic [7:0] OPC_ST_HL     = 8'h22;
  localparam logic [7:0] OPC_IMM_HL    = 8'h21;
  localparam logic [7:0] OPC_IMM_DE    = 8'h11;
  localparam logic [7:0] OPC_ST_ACC_DE = 8'h12;

  typedef enum logic [2:0] {
    CLS_LD_ACC, CLS_ST_ACC, CLS_LD_HL, CLS_ST_HL,
    CLS_IMM_HL, CLS_IMM_DE, CLS_ST_ACC_DE, CLS_BAD
  } opClass_t;

  typedef enum logic [2:0] {
    MC_FETCH, MC_OPLO, MC_OPHI, MC_DRD, MC_DWR, MC_HALT
  } mcKind_t;

  typedef enum logic [1:0] {ASEL_PC, ASEL_TMP, ASEL_TMP1, ASEL_DE} addrSel_t;
  typedef enum logic [1:0] {WSEL_A, WSEL_L, WSEL_H} wrSel_t;

  typedef struct packed {
    addrSel_t addrSel;
    wrSel_t   wrSel;
    logic     pcInc;
    logic     ldTmpLo;
    logic     ldTmpHi;
    logic     ldA;
    logic     ldL;
    logic     ldH;
    logic     ldE;
    logic     ldD;
  } dpCtrl_t;

  function automatic opClass_t decodeOp(input logic [DATA_W-1:0] op);
    case (op)
      OPC_LD_ACC:    return CLS_LD_ACC;
      OPC_ST_ACC:    return CLS_ST_ACC;
      OPC_LD_HL:     return CLS_LD_HL;
      OPC_ST_HL:     return CLS_ST_HL;
      OPC_IMM_HL:    return CLS_IMM_HL;
      OPC_IMM_DE:    return CLS_IMM_DE;
      OPC_ST_ACC_DE: return CLS_ST_ACC_DE;
      default:       return CLS_BAD;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] lenOf(input opClass_t c);
    case (c)
      CLS_ST_ACC_DE, CLS_BAD: return LEN_W'(1);
      default:                return LEN_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rdByte,
  output dpCtrl_t           ctl,
  output logic              memRd,
  output logic              memWr,
  output logic              done,
  output logic [LEN_W-1:0]  instrLen,
  output logic              halted
);
  mcKind_t           mc, nextMc;
  logic [TCNT_W-1:0] tCnt;
  logic              second, nextSecond;
  opClass_t          opCls, curCls;
  logic [LEN_W-1:0]  lenQ;
  logic              lastT;

  assign lastT  = (mc == MC_FETCH) ? (tCnt == TCNT_W'(FETCH_STATES - 1))
                                   : (tCnt == TCNT_W'(MEM_STATES - 1));
  assign curCls = (mc == MC_FETCH) ? decodeOp(rdByte) : opCls;

  // Which machine cycle follows the current one
  always_comb begin
    nextMc     = mc;
    nextSecond = 1'b0;
    case (mc)
      MC_FETCH: begin
        if (curCls == CLS_BAD)            nextMc = MC_HALT;
        else if (curCls == CLS_ST_ACC_DE) nextMc = MC_DWR;
        else                              nextMc = MC_OPLO;
      end
      MC_OPLO: nextMc = MC_OPHI;
      MC_OPHI: begin
        if (curCls == CLS_IMM_HL || curCls == CLS_IMM_DE)     nextMc = MC_FETCH;
        else if (curCls == CLS_LD_ACC || curCls == CLS_LD_HL) nextMc = MC_DRD;
        else                                                  nextMc = MC_DWR;
      end
      MC_DRD: begin
        if (curCls == CLS_LD_HL && !second) begin
          nextMc = MC_DRD;  nextSecond = 1'b1;
        end else nextMc = MC_FETCH;
      end
      MC_DWR: begin
        if (curCls == CLS_ST_HL && !second) begin
          nextMc = MC_DWR;  nextSecond = 1'b1;
        end else nextMc = MC_FETCH;
      end
      default: nextMc = MC_HALT;
    endcase
  end

  // Strobes toward the datapath
  always_comb begin
    ctl   = '0;
    memRd = 1'b0;
    memWr = 1'b0;
    case (mc)
      MC_FETCH: begin
        memRd     = 1'b1;
        ctl.pcInc = lastT;
      end
      MC_OPLO: begin
        memRd     = 1'b1;
        ctl.pcInc = lastT;
        if (curCls == CLS_IMM_HL)      ctl.ldL     = lastT;
        else if (curCls == CLS_IMM_DE) ctl.ldE     = lastT;
        else                           ctl.ldTmpLo = lastT;
      end
      MC_OPHI: begin
        memRd     = 1'b1;
        ctl.pcInc = lastT;
        if (curCls == CLS_IMM_HL)      ctl.ldH     = lastT;
        else if (curCls == CLS_IMM_DE) ctl.ldD     = lastT;
        else                           ctl.ldTmpHi = lastT;
      end
      MC_DRD: begin
        memRd       = 1'b1;
        ctl.addrSel = second ? ASEL_TMP1 : ASEL_TMP;
        if (curCls == CLS_LD_ACC) ctl.ldA = lastT;
        else if (second)          ctl.ldH = lastT;
        else                      ctl.ldL = lastT;
      end
      MC_DWR: begin
        memWr = lastT;
        if (curCls == CLS_ST_ACC_DE) ctl.addrSel = ASEL_DE;
        else                         ctl.addrSel = second ? ASEL_TMP1 : ASEL_TMP;
        if (curCls == CLS_ST_HL) ctl.wrSel = second ? WSEL_H : WSEL_L;
        else                     ctl.wrSel = WSEL_A;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc     <= MC_FETCH;
      tCnt   <= '0;
      second <= 1'b0;
      opCls  <= CLS_BAD;
      lenQ   <= '0;
    end else if (mc != MC_HALT) begin
      if (lastT) begin
        tCnt   <= '0;
        mc     <= nextMc;
        second <= nextSecond;
        if (mc == MC_FETCH) begin
          opCls <= curCls;
          lenQ  <= lenOf(curCls);
        end
      end else begin
        tCnt <= tCnt + 1'b1;
      end
    end
  end

  assign done     = lastT && (mc != MC_FETCH) && (mc != MC_HALT) && (nextMc == MC_FETCH);
  assign instrLen = lenQ;
  assign halted   = (mc == MC_HALT);

  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));
  p_cycle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!lastT && !halted) |=> $stable(mc));
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!memRd && !memWr));
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] rdByte,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrByte,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] regH,
  output logic [DATA_W-1:0] regL,
  output logic [DATA_W-1:0] regD,
  output logic [DATA_W-1:0] regE
);
  logic [DATA_W-1:0] tmpLo, tmpHi;
  logic [ADDR_W-1:0] tmpAddr, tmpNext;

  assign tmpAddr = {tmpHi, tmpLo};
  assign tmpNext = tmpAddr + 1'b1;

  always_comb begin
    case (ctl.addrSel)
      ASEL_TMP:  addr = tmpAddr;
      ASEL_TMP1: addr = tmpNext;
      ASEL_DE:   addr = {regD, regE};
      default:   addr = pc;
    endcase
  end

  always_comb begin
    case (ctl.wrSel)
      WSEL_L:  wrByte = regL;
      WSEL_H:  wrByte = regH;
      default: wrByte = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      tmpLo <= '0;
      tmpHi <= '0;
      acc   <= '0;
      regH  <= '0;
      regL  <= '0;
      regD  <= '0;
      regE  <= '0;
    end else begin
      if (ctl.pcInc)   pc    <= pc + 1'b1;
      if (ctl.ldTmpLo) tmpLo <= rdByte;
      if (ctl.ldTmpHi) tmpHi <= rdByte;
      if (ctl.ldA)     acc   <= rdByte;
      if (ctl.ldH)     regH  <= rdByte;
      if (ctl.ldL)     regL  <= rdByte;
      if (ctl.ldD)     regD  <= rdByte;
      if (ctl.ldE)     regE  <= rdByte;
    end
  end
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              done,
  output logic [LEN_W-1:0]  instrLen,
  output logic              halted,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] hOut,
  output logic [DATA_W-1:0] lOut,
  output logic [DATA_W-1:0] dOut,
  output logic [DATA_W-1:0] eOut
);
  dpCtrl_t ctl;

  xfer_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .rdByte   (memRdData),
    .ctl      (ctl),
    .memRd    (memRd),
    .memWr    (memWr),
    .done     (done),
    .instrLen (instrLen),
    .halted   (halted)
  );

  xfer_datapath uDp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .rdByte (memRdData),
    .addr   (memAddr),
    .wrByte (memWrData),
    .pc     (pcOut),
    .acc    (accOut),
    .regH   (hOut),
    .regL   (lOut),
    .regD   (dOut),
    .regE   (eOut)
  );

  p_pc_still_on_write_r2: assert property (@(posedge clk) disable iff (rst)
    memWr |=> $stable(pcOut));
  p_halt_regs_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(accOut) && $stable(hOut) && $stable(lOut) && $stable(pcOut)));
endmodule

// File: tb/xfer_sequencer_test.sv
module xfer_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memAddr;
  logic        memRd, memWr, done, halted;
  logic [7:0]  memRdData, memWrData;
  logic [1:0]  instrLen;
  logic [15:0] pcOut;
  logic [7:0]  accOut, hOut, lOut, dOut, eOut;

  logic [7:0]  mem [0:1023];
  logic [15:0] wrLogA [0:15];
  logic [7:0]  wrLogD [0:15];
  int          wrCount = 0;
  int          nChecks = 0;
  int          nFail   = 0;

  always #5 clk = ~clk;

  assign memRdData = mem[memAddr[9:0]];

  always @(posedge clk) begin
    if (memWr) begin
      mem[memAddr[9:0]]     <= memWrData;
      wrLogA[wrCount[3:0]]  <= memAddr;
      wrLogD[wrCount[3:0]]  <= memWrData;
      wrCount               <= wrCount + 1;
    end
  end

  xfer_sequencer uut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memRdData(memRdData), .memWrData(memWrData), .done(done),
    .instrLen(instrLen), .halted(halted), .pcOut(pcOut), .accOut(accOut),
    .hOut(hOut), .lOut(lOut), .dOut(dOut), .eOut(eOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one instruction from T1 of its fetch to done, then steps past the final edge
  task automatic execOne(input string req, input logic [15:0] expPc, input int expStates,
                         input logic [1:0] expLen, input int expWr);
    int  n = 0;
    bit  fetchOk = 1'b1;
    bit  exclOk  = 1'b1;
    int  w0 = wrCount;
    while (1) begin
      @(negedge clk);
      n++;
      if (n <= 4 && !(memRd && memAddr == expPc)) fetchOk = 1'b0;
      if (memRd && memWr) exclOk = 1'b0;
      if (done || n >= 40) break;
    end
    chk({req, " state count"}, n, expStates);
    chk("R2 opcode fetch from pc for 4 states", fetchOk, 1);
    chk("R9 instrLen at done", instrLen, expLen);
    chk("R11 read/write exclusive", exclOk, 1);
    @(posedge clk); #2;
    chk({req, " write strobes"}, wrCount - w0, expWr);
    chk("R9 done single clock", done, 0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pcOut, 0);
    chk("R1 regs", {accOut, hOut, lOut, dOut, eOut}, 0);
    chk("R1 strobes", {memWr, done, halted}, 0);
    chk("R1 address", memAddr, 0);
    @(posedge clk); #2;
    rst = 1'b0;
  endtask

  task automatic testImmPairs();
    execOne("R7 imm HL", 16'h0000, 10, 2'd3, 0);
    chk("R7 HL value", {hOut, lOut}, 16'h1234);
    chk("R2 pc after imm", pcOut, 16'h0003);
    execOne("R7 imm DE", 16'h0003, 10, 2'd3, 0);
    chk("R7 DE value", {dOut, eOut}, 16'h5678);
  endtask

  task automatic testAccDirect();
    execOne("R3 load acc direct", 16'h0006, 13, 2'd3, 0);
    chk("R3 acc value", accOut, 8'hA5);
    chk("R3 pc", pcOut, 16'h0009);
    execOne("R4 store acc direct", 16'h0009, 13, 2'd3, 1);
    chk("R4 write addr", wrLogA[0], 16'h0210);
    chk("R4 write data", wrLogD[0], 8'hA5);
    chk("R2 pc after store", pcOut, 16'h000C);
  endtask

  task automatic testHlDirect();
    execOne("R5 load HL direct", 16'h000C, 16, 2'd3, 0);
    chk("R5 L from addr", lOut, 8'h3C);
    chk("R5 H from addr+1", hOut, 8'hC3);
    execOne("R6 store HL direct", 16'h000F, 16, 2'd3, 2);
    chk("R6 first write", {wrLogA[1], wrLogD[1]}, {16'h0230, 8'h3C});
    chk("R6 second write", {wrLogA[2], wrLogD[2]}, {16'h0231, 8'hC3});
  endtask

  task automatic testStoreViaDe();
    execOne("R7 imm DE again", 16'h0012, 10, 2'd3, 0);
    execOne("R8 store acc via DE", 16'h0015, 7, 2'd1, 1);
    chk("R8 write", {wrLogA[3], wrLogD[3]}, {16'h0240, 8'hA5});
    chk("R8 pc", pcOut, 16'h0016);
  endtask

  task automatic testWrap();
    execOne("R12 load HL at FFFF", 16'h0016, 16, 2'd3, 0);
    chk("R12 L from FFFF", lOut, 8'h5E);
    chk("R12 H from 0000", hOut, 8'h21);
    execOne("R12 store HL at FFFF", 16'h0019, 16, 2'd3, 2);
    chk("R12 first write addr", wrLogA[4], 16'hFFFF);
    chk("R12 wrapped write addr", wrLogA[5], 16'h0000);
  endtask

  task automatic testHalt();
    int  w0 = wrCount;
    bit  quiet = 1'b1;
    repeat (4) @(negedge clk);
    @(posedge clk); #2;
    chk("R10 halted after fetch", halted, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (memRd || memWr || !halted || done) quiet = 1'b0;
    end
    chk("R10 no activity while halted", quiet, 1);
    chk("R10 pc frozen", pcOut, 16'h001D);
    chk("R10 regs frozen", {accOut, hOut, lOut, dOut, eOut}, {8'hA5, 8'h21, 8'h5E, 8'h02, 8'h40});
    chk("R10 no writes", wrCount - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem['h00] = 8'h21; mem['h01] = 8'h34; mem['h02] = 8'h12;
    mem['h03] = 8'h11; mem['h04] = 8'h78; mem['h05] = 8'h56;
    mem['h06] = 8'h3A; mem['h07] = 8'h00; mem['h08] = 8'h02;
    mem['h09] = 8'h32; mem['h0A] = 8'h10; mem['h0B] = 8'h02;
    mem['h0C] = 8'h2A; mem['h0D] = 8'h20; mem['h0E] = 8'h02;
    mem['h0F] = 8'h22; mem['h10] = 8'h30; mem['h11] = 8'h02;
    mem['h12] = 8'h11; mem['h13] = 8'h40; mem['h14] = 8'h02;
    mem['h15] = 8'h12;
    mem['h16] = 8'h2A; mem['h17] = 8'hFF; mem['h18] = 8'hFF;
    mem['h19] = 8'h22; mem['h1A] = 8'hFF; mem['h1B] = 8'hFF;
    mem['h1C] = 8'hC3;
    mem['h200] = 8'hA5;
    mem['h220] = 8'h3C; mem['h221] = 8'hC3;
    mem['h3FF] = 8'h5E;

    doReset();
    testImmPairs();
    testAccDirect();
    testHlDirect();
    testStoreViaDe();
    testWrap();
    testHalt();
    doReset();
    chk("R1 halt cleared by reset", halted, 0);
    execOne("R7 imm HL after reset", 16'h0000, 10, 2'd3, 0);
    chk("R7 HL after reset", {hOut, lOut}, 16'h1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule